// File: doc/BRIEF.md
# Accumulator and Link Operation Unit

This block owns the working accumulator of a small 16-bit processor and the single link bit that sits beside it. It carries out all register-to-register operations on that pair: clearing, complementing, rotating through the link bit in either direction, and incrementing. It also takes results from the memory operand path (bitwise AND, add with carry, and plain load) and an 8-bit byte from the input port. The sequencer presents an operation code together with a one-cycle strobe in the execute timing slot. The new accumulator and link values appear after the next clock edge.

Four of the codes are conditional tests on the sign of the accumulator, on an all-zero accumulator, or on a clear link bit. For these codes the block raises a skip request in the same cycle as the strobe, and the sequencer uses that request to advance the program counter an extra step. Instruction decode and memory access belong to the surrounding control unit.

Top module: `acc_link_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `acc` is 0, `link` is 0 and `skip_req` is 0.
- R2: When `op_valid` is 0, `acc` and `link` keep their values and `skip_req` is 0. Code 0 (no-op) with `op_valid` at 1 also changes nothing and requests no skip.
- R3: With `op_valid` at 1, the following codes act on the next edge and leave the other register unchanged: code 1 clears `acc`, code 2 clears `link`, code 3 inverts every bit of `acc`, and code 4 inverts `link`.
- R4: Code 5 rotates right through the link. The new `acc` is {old link, old acc[15:1]} and the new `link` is old acc[0].
- R5: Code 6 rotates left through the link. The new `acc` is {old acc[14:0], old link} and the new `link` is old acc[15].
- R6: Code 7 adds one to `acc` modulo 2^16. `link` is unchanged, including when `acc` wraps from 0xFFFF to 0.
- R7: In the same cycle as a strobe, code 8 sets `skip_req` when acc[15] is 0, and code 9 sets it when acc[15] is 1.
- R8: In the same cycle as a strobe, code 10 sets `skip_req` when `acc` is 0, and code 11 sets it when `link` is 0.
- R9: `skip_req` is 1 only in a cycle where `op_valid` is 1 and the code is one of 8 to 11. Codes 8 to 11 leave `acc` and `link` unchanged.
- R10: Code 12 writes `acc & mem_data` to `acc`, and code 14 writes `mem_data` to `acc`. Both leave `link` unchanged.
- R11: Code 13 forms the 17-bit sum `acc + mem_data`. On the same edge, `acc` takes the low 16 bits and `link` takes the carry out.
- R12: Code 15 writes `in_byte` into acc[7:0]. acc[15:8] and `link` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Execute-slot strobe from the sequencer |
| op_code | input | 4 | Operation selector (codes 0 to 15, see requirements) |
| mem_data | input | 16 | Operand word from the memory path |
| in_byte | input | 8 | Byte from the input port |
| skip_req | output | 1 | Program-counter skip request, valid in the strobe cycle |
| acc | output | 16 | Accumulator |
| link | output | 1 | Link bit |

## Verification
The hardest states to reach from the ports are the ones where the link bit meets the data at an edge. These include a rotate that carries a set link into acc[15] or acc[0], an add whose carry overwrites a link that was already set, and an increment that wraps 0xFFFF while the link stays at 1. The stimulus builds these states on purpose through load, complement and add codes before applying the code under test. Each skip test is run both with its condition true and with it false, and a zero accumulator is produced by clear, by wraparound and by add. A long pseudo-random stream then mixes strobed and idle cycles across all codes. A behavioural model built on integer arithmetic is compared with the outputs on every cycle.

// File: rtl/acc_link_pkg.sv
package acc_link_pkg;
  typedef enum logic [3:0] {
    OP_NOP     = 4'd0,
    OP_CLR_AC  = 4'd1,
    OP_CLR_LK  = 4'd2,
    OP_INV_AC  = 4'd3,
    OP_INV_LK  = 4'd4,
    OP_ROT_R   = 4'd5,
    OP_ROT_L   = 4'd6,
    OP_INCR    = 4'd7,
    OP_SK_POS  = 4'd8,
    OP_SK_NEG  = 4'd9,
    OP_SK_ZAC  = 4'd10,
    OP_SK_ZLK  = 4'd11,
    OP_AND_MEM = 4'd12,
    OP_ADD_MEM = 4'd13,
    OP_LD_MEM  = 4'd14,
    OP_LD_BYTE = 4'd15
  } alu_op_e;
endpackage

// File: rtl/acc_link_alu.sv
module acc_link_alu
  import acc_link_pkg::*;
#(
  parameter int unsigned W      = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  alu_op_e           op,
  input  logic [W-1:0]      ac,
  input  logic              lk,
  input  logic [W-1:0]      operand,
  input  logic [BYTE_W-1:0] in_byte,
  output logic [W-1:0]      ac_nxt,
  output logic              lk_nxt
);
  localparam int unsigned WIDE = W + 1;

  // {link, acc} after a right rotate through the link
  function automatic logic [WIDE-1:0] rot_right(input logic [W-1:0] a, input logic l);
    return {a[0], l, a[W-1:1]};
  endfunction

  // {link, acc} after a left rotate through the link
  function automatic logic [WIDE-1:0] rot_left(input logic [W-1:0] a, input logic l);
    return {a[W-1], a[W-2:0], l};
  endfunction

  // {carry, sum}
  function automatic logic [WIDE-1:0] add_carry(input logic [W-1:0] a, input logic [W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  logic [WIDE-1:0] rr_res, rl_res, add_res;
  assign rr_res  = rot_right(ac, lk);
  assign rl_res  = rot_left(ac, lk);
  assign add_res = add_carry(ac, operand);

  always_comb begin
    ac_nxt = ac;
    lk_nxt = lk;
    case (op)
      OP_CLR_AC:  ac_nxt = '0;
      OP_CLR_LK:  lk_nxt = 1'b0;
      OP_INV_AC:  ac_nxt = ~ac;
      OP_INV_LK:  lk_nxt = ~lk;
      OP_ROT_R:   {lk_nxt, ac_nxt} = rr_res;
      OP_ROT_L:   {lk_nxt, ac_nxt} = rl_res;
      OP_INCR:    ac_nxt = ac + W'(1);
      OP_AND_MEM: ac_nxt = ac & operand;
      OP_ADD_MEM: {lk_nxt, ac_nxt} = add_res;
      OP_LD_MEM:  ac_nxt = operand;
      OP_LD_BYTE: ac_nxt = {ac[W-1:BYTE_W], in_byte};
      default: begin
        ac_nxt = ac;
        lk_nxt = lk;
      end
    endcase
  end
endmodule

// File: rtl/acc_link_skip.sv
module acc_link_skip
  import acc_link_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  alu_op_e      op,
  input  logic [W-1:0] ac,
  input  logic         lk,
  output logic         skip
);
  logic cond;
  always_comb begin
    case (op)
      OP_SK_POS: cond = ~ac[W-1];
      OP_SK_NEG: cond = ac[W-1];
      OP_SK_ZAC: cond = (ac == '0);
      OP_SK_ZLK: cond = ~lk;
      default:   cond = 1'b0;
    endcase
  end
  assign skip = strobe & cond;

  // R9
  skip_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> (strobe && (op inside {OP_SK_POS, OP_SK_NEG, OP_SK_ZAC, OP_SK_ZLK})));
  // R8
  skip_zero_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && op == OP_SK_ZAC) |-> (skip == (ac == '0)));
endmodule

// File: rtl/acc_link_unit.sv
module acc_link_unit
  import acc_link_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [DATA_W-1:0] mem_data,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              skip_req,
  output logic [DATA_W-1:0] acc,
  output logic              link
);
  alu_op_e           op_e;
  logic [DATA_W-1:0] ac_q, ac_nxt;
  logic              lk_q, lk_nxt;

  assign op_e = alu_op_e'(op_code);

  // named events for the checks
  logic ev_add, ev_rot_r, ev_inv_lk, ev_incr;
  assign ev_add    = op_valid && (op_e == OP_ADD_MEM);
  assign ev_rot_r  = op_valid && (op_e == OP_ROT_R);
  assign ev_inv_lk = op_valid && (op_e == OP_INV_LK);
  assign ev_incr   = op_valid && (op_e == OP_INCR);

  acc_link_alu #(.W(DATA_W), .BYTE_W(BYTE_W)) u_alu (
    .op      (op_e),
    .ac      (ac_q),
    .lk      (lk_q),
    .operand (mem_data),
    .in_byte (in_byte),
    .ac_nxt  (ac_nxt),
    .lk_nxt  (lk_nxt)
  );

  acc_link_skip #(.W(DATA_W)) u_skip (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (op_valid),
    .op     (op_e),
    .ac     (ac_q),
    .lk     (lk_q),
    .skip   (skip_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ac_q <= '0;
      lk_q <= 1'b0;
    end else if (op_valid) begin
      ac_q <= ac_nxt;
      lk_q <= lk_nxt;
    end
  end

  assign acc  = ac_q;
  assign link = lk_q;

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(ac_q) && $stable(lk_q)));
  // R11
  add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_add |=> ({lk_q, ac_q} == ({1'b0, $past(ac_q)} + {1'b0, $past(mem_data)})));
  // R4
  rot_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rot_r |=> (lk_q == $past(ac_q[0]) && ac_q[DATA_W-1] == $past(lk_q)));
  // R3
  inv_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_inv_lk |=> (lk_q != $past(lk_q) && $stable(ac_q)));
  // R6
  incr_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_incr |=> $stable(lk_q));
endmodule

// File: tb/acc_link_unit_bench.sv
module acc_link_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = 4'd0;
  logic [15:0] mem_data = 16'd0;
  logic [7:0]  in_byte = 8'd0;
  logic        skip_req;
  logic [15:0] acc;
  logic        link;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_ac = 16'd0;
  logic        m_lk = 1'b0;

  always #5 clk = ~clk;

  acc_link_unit u_acc_link_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .mem_data(mem_data), .in_byte(in_byte), .skip_req(skip_req),
    .acc(acc), .link(link)
  );

  function automatic string tag_of(input logic v, input logic [3:0] op);
    if (!v || op == 4'd0) return "R2";
    case (op)
      4'd1, 4'd2, 4'd3, 4'd4: return "R3";
      4'd5: return "R4";
      4'd6: return "R5";
      4'd7: return "R6";
      4'd8, 4'd9: return "R7";
      4'd10, 4'd11: return "R8";
      4'd13: return "R11";
      4'd15: return "R12";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [3:0] op, input logic [15:0] d, input logic [7:0] b);
    logic exp_skip;
    int   sum;
    op_valid = v; op_code = op; mem_data = d; in_byte = b;
    #1;
    exp_skip = 1'b0;
    if (v) begin
      if (op == 4'd8  && m_ac < 16'h8000) exp_skip = 1'b1;
      if (op == 4'd9  && m_ac >= 16'h8000) exp_skip = 1'b1;
      if (op == 4'd10 && m_ac == 16'd0) exp_skip = 1'b1;
      if (op == 4'd11 && m_lk == 1'b0) exp_skip = 1'b1;
    end
    // R9: skip only in strobe cycle with a test code
    check((op >= 4'd8 && op <= 4'd11 && v) ? tag_of(v, op) : "R9", "skip", skip_req, exp_skip);
    @(posedge clk);
    if (v) begin
      case (op)
        4'd1: m_ac = 16'd0;
        4'd2: m_lk = 1'b0;
        4'd3: m_ac = 16'hFFFF - m_ac;
        4'd4: m_lk = !m_lk;
        4'd5: begin
          sum  = m_ac % 2;
          m_ac = (m_ac / 2) + (m_lk ? 16'h8000 : 16'h0);
          m_lk = (sum == 1);
        end
        4'd6: begin
          sum  = m_ac / 32768;
          m_ac = ((m_ac * 2) % 65536) + (m_lk ? 1 : 0);
          m_lk = (sum == 1);
        end
        4'd7: m_ac = (int'(m_ac) + 1) % 65536;
        4'd12: m_ac = m_ac & d;
        4'd13: begin
          sum  = int'(m_ac) + int'(d);
          m_lk = (sum > 65535);
          m_ac = sum % 65536;
        end
        4'd14: m_ac = d;
        4'd15: m_ac = (m_ac / 256) * 256 + int'(b);
        default: ;
      endcase
    end
    @(negedge clk);
    check((v && op >= 4'd8 && op <= 4'd11) ? "R9" : tag_of(v, op), "acc", acc, m_ac);
    check((v && op >= 4'd8 && op <= 4'd11) ? "R9" : tag_of(v, op), "link", link, m_lk);
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "acc", acc, 0);
    check("R1", "link", link, 0);
    check("R1", "skip", skip_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "acc after release", acc, 0);
    // directed corners
    step(1, 4'd11, 0, 0);          // R8 link zero -> skip
    step(1, 4'd10, 0, 0);          // R8 acc zero -> skip
    step(1, 4'd8, 0, 0);           // R7 positive
    step(1, 4'd14, 16'h8001, 0);   // R10 load
    step(1, 4'd9, 0, 0);           // R7 negative
    step(1, 4'd8, 0, 0);           // R7 no skip
    step(0, 4'd1, 0, 0);           // R2 idle ignored
    step(1, 4'd0, 16'h1234, 8'h55);// R2 no-op
    step(1, 4'd5, 0, 0);           // R4 acc[0]=1 to link
    step(1, 4'd5, 0, 0);           // R4 link=1 into acc[15]
    step(1, 4'd6, 0, 0);           // R5
    step(1, 4'd6, 0, 0);           // R5
    step(1, 4'd4, 0, 0);           // R3
    step(1, 4'd11, 0, 0);          // R8 link set -> no skip
    step(1, 4'd14, 16'hFFFF, 0);
    step(1, 4'd7, 0, 0);           // R6 wrap, link kept
    step(1, 4'd10, 0, 0);          // R8
    step(1, 4'd3, 0, 0);           // R3 invert
    step(1, 4'd13, 16'h0001, 0);   // R11 carry out
    step(1, 4'd13, 16'h7FFF, 0);   // R11 no carry clears link
    step(1, 4'd12, 16'h0F0F, 0);   // R10 and
    step(1, 4'd14, 16'hAB00, 0);
    step(1, 4'd15, 0, 8'hCD);      // R12
    step(1, 4'd4, 0, 0);
    step(1, 4'd15, 0, 8'h12);      // R12 link kept
    step(1, 4'd1, 0, 0);           // R3
    step(1, 4'd2, 0, 0);           // R3
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] rop;
      rop = 4'($urandom_range(0, 15));
      step(($urandom_range(0, 3) != 0), rop, 16'($urandom), 8'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule